// File: doc/BRIEF.md
# TDM Signalling Timeslot Gate

This block derives, from the bit clock and frame pulse of a 32-channel serial TDM stream, the timing needed to steer one timeslot to a serial signalling controller. It keeps a bit counter and a timeslot counter locked to the frame pulse. From the next value of those counters it produces three registered timing outputs:

- a one-bit control strobe that precedes the signalling window;
- a port enable that spans the window;
- a high-impedance request for the switch's serial data output, active over the same window.

The strobe sits on the final bit of the slot that comes before the signalling slot. An external port working in PCM framing therefore opens exactly on the slot boundary and stays open for eight bit clocks. The same bit clock shifts controller data in both directions. The signalling slot is a parameter, 16 by default. Bits within a slot are numbered 7 down to 0 in transmission order. An active-low frame pulse sampled at a clock edge forces timeslot 0, bit 7 on that edge, even when it arrives at an unexpected count.

Top module: `tdm_sig_gate`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the next state is timeslot 0, bit 7, with strobe, port enable and high-impedance request all low.
- R2: A frame pulse sampled low at a clock edge makes the counters read timeslot 0, bit 7 after that edge, whatever their previous value.
- R3: With no frame pulse, the bit index counts 7 down to 0 once per clock. After bit 0 it returns to 7 and the timeslot index advances by one, wrapping from 31 to 0.
- R4: The control strobe is high exactly while the counters read bit 0 of the slot before the signalling slot (slot 15 by default). That gives one bit period per frame.
- R5: The port enable is high exactly while the counters read the signalling slot, which is eight consecutive bit periods in an undisturbed frame.
- R6: The high-impedance request for the switch output equals the port enable in every cycle.
- R7: The port enable rises only in the cycle right after a cycle in which the strobe was high and no frame pulse was sampled.
- R8: The port enable is never high for more than eight consecutive cycles.
- R9: A frame pulse sampled during the signalling window makes the port enable and high-impedance request low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, one cycle per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse, sampled on the rising edge |
| ctl_strobe | output | 1 | Control strobe, one bit period before the window |
| port_en | output | 1 | Signalling controller port enable |
| sw_hiz | output | 1 | High-impedance request for the switch data output |
| slot_idx | output | 5 | Current timeslot index |
| bit_idx | output | 3 | Current bit index, 7 first |

## Verification
The bench drives several distinct frame-pulse patterns:

- A free run with no pulse shows that the counters wrap on their own.
- Regular pulses every 256 cycles show that a correctly timed pulse changes nothing.
- Pulses at irregular gaps show that re-alignment can happen at any count.
- A pulse inside the window separates truncation from a window that runs on.
- A pulse on the strobe bit itself shows that no window opens without a clean strobe.

Over four aligned frames, the bench totals strobe and high-impedance cycles to confirm one and eight per frame.

// File: rtl/tdm_sig_pkg.sv
// Package: shared types and helpers for the signalling timeslot gate.
// Assumes slot and bit counts are powers of two or any value >= 2.
package tdm_sig_pkg;

    // Registered timing flags produced by the window decoder.
    typedef struct packed {
        logic strobe;
        logic port_en;
        logic hiz;
    } sig_flags_t;

    // Index of the slot that precedes a given slot, wrapping at zero.
    function automatic int unsigned prev_slot(input int unsigned slot,
                                              input int unsigned num_slots);
        return (slot + num_slots - 1) % num_slots;
    endfunction

endpackage

// File: rtl/tdm_frame_counter.sv
// Module: bit and timeslot counter locked to an active-low frame pulse.
// Bits count down from BITS_PER_SLOT-1 to 0; the slot advances after bit 0.
// Exposes both the registered count and the value it will load next, so
// downstream logic can register decodes that line up with the count.
// Assumes frame_n is already synchronous to clk.
module tdm_frame_counter #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int BW = $clog2(BITS_PER_SLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    output logic [SW-1:0] slot_q,
    output logic [BW-1:0] bit_q,
    output logic [SW-1:0] slot_nx,
    output logic [BW-1:0] bit_nx
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
    localparam logic [BW-1:0] TOP_BIT   = BW'(BITS_PER_SLOT - 1);

    // Next count: frame pulse wins, otherwise step the bit and roll the slot.
    always_comb begin
        slot_nx = slot_q;
        bit_nx  = bit_q;
        if (!frame_n) begin
            slot_nx = '0;
            bit_nx  = TOP_BIT;
        end else if (bit_q == '0) begin
            bit_nx  = TOP_BIT;
            slot_nx = (slot_q == LAST_SLOT) ? '0 : slot_q + SW'(1);
        end else begin
            bit_nx  = bit_q - BW'(1);
        end
    end

    // Count register with synchronous reset to the frame origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= TOP_BIT;
        end else begin
            slot_q <= slot_nx;
            bit_q  <= bit_nx;
        end
    end

endmodule

// File: rtl/sig_window_decode.sv
// Module: registered decode of the signalling window from the next count.
// Decoding the next count and registering it makes every flag change on the
// same edge that starts its bit, with no combinational path to the ports.
// Assumes SIG_SLOT < NUM_SLOTS.
module sig_window_decode
    import tdm_sig_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    parameter int SIG_SLOT      = 16,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int BW = $clog2(BITS_PER_SLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot_nx,
    input  logic [BW-1:0] bit_nx,
    output sig_flags_t    flags_q
);
    localparam logic [SW-1:0] SIG_IDX  = SW'(SIG_SLOT);
    localparam logic [SW-1:0] PREV_IDX = SW'(prev_slot(SIG_SLOT, NUM_SLOTS));
    localparam logic [BW-1:0] TOP_BIT  = BW'(BITS_PER_SLOT - 1);

    sig_flags_t flags_d;

    // Flags for a given count value.
    function automatic sig_flags_t decode(input logic [SW-1:0] s,
                                          input logic [BW-1:0] b);
        sig_flags_t f;
        f.strobe  = (s == PREV_IDX) && (b == '0);
        f.port_en = (s == SIG_IDX);
        f.hiz     = (s == SIG_IDX);
        return f;
    endfunction

    localparam sig_flags_t RST_FLAGS = decode('0, TOP_BIT);

    // Decode of the count that loads on the coming edge.
    always_comb flags_d = decode(slot_nx, bit_nx);

    // Flag register; reset value matches the decode of the reset count.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= RST_FLAGS;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/tdm_sig_gate.sv
// Module: top of the signalling timeslot gate.
// Produces a one-bit lead strobe, a port enable for one timeslot and a
// high-impedance request for the switch output over the same timeslot.
// Assumes a single clock domain (the bit clock) and a synchronous frame pulse.
module tdm_sig_gate
    import tdm_sig_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    parameter int SIG_SLOT      = 16,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int BW = $clog2(BITS_PER_SLOT)
) (
    input  logic          clk_bit,
    input  logic          rst_n,
    input  logic          frame_n,
    output logic          ctl_strobe,
    output logic          port_en,
    output logic          sw_hiz,
    output logic [SW-1:0] slot_idx,
    output logic [BW-1:0] bit_idx
);
    logic [SW-1:0] slot_nx;
    logic [BW-1:0] bit_nx;
    sig_flags_t    flags;

    tdm_frame_counter #(
        .NUM_SLOTS    (NUM_SLOTS),
        .BITS_PER_SLOT(BITS_PER_SLOT)
    ) u_cnt (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .frame_n(frame_n),
        .slot_q (slot_idx),
        .bit_q  (bit_idx),
        .slot_nx(slot_nx),
        .bit_nx (bit_nx)
    );

    sig_window_decode #(
        .NUM_SLOTS    (NUM_SLOTS),
        .BITS_PER_SLOT(BITS_PER_SLOT),
        .SIG_SLOT     (SIG_SLOT)
    ) u_dec (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .slot_nx(slot_nx),
        .bit_nx (bit_nx),
        .flags_q(flags)
    );

    // Port mapping of the registered flags.
    assign ctl_strobe = flags.strobe;
    assign port_en    = flags.port_en;
    assign sw_hiz     = flags.hiz;

endmodule

// File: rtl/tdm_sig_gate_chk.sv
// Module: property checker for tdm_sig_gate, attached by bind.
// Assumes SIG_SLOT is not 0 for the window-opening properties.
module tdm_sig_gate_chk #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    parameter int SIG_SLOT      = 16,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int BW = $clog2(BITS_PER_SLOT)
) (
    input logic          clk_bit,
    input logic          rst_n,
    input logic          frame_n,
    input logic          ctl_strobe,
    input logic          port_en,
    input logic          sw_hiz,
    input logic [SW-1:0] slot_idx,
    input logic [BW-1:0] bit_idx
);
    localparam logic [SW-1:0] SIG_IDX  = SW'(SIG_SLOT);
    localparam logic [SW-1:0] PREV_IDX = SW'((SIG_SLOT + NUM_SLOTS - 1) % NUM_SLOTS);
    localparam logic [BW-1:0] TOP_BIT  = BW'(BITS_PER_SLOT - 1);

    logic       rst_seen_q;
    int unsigned run_q;

    // Remembers that reset was sampled low on the previous edge.
    always_ff @(posedge clk_bit) rst_seen_q <= !rst_n;

    // Length of the current port-enable run.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)       run_q <= 0;
        else if (port_en) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    // R1
    always @(posedge clk_bit) begin
        if (rst_seen_q) begin
            reset_state_chk: assert (slot_idx == '0 && bit_idx == TOP_BIT &&
                                     !ctl_strobe && !port_en && !sw_hiz);
        end
    end

    // R2
    realign_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (rst_n && !frame_n) |=> (slot_idx == '0 && bit_idx == TOP_BIT));

    // R3
    bit_step_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (rst_n && frame_n && bit_idx != '0) |=> (bit_idx == $past(bit_idx) - BW'(1)));

    // R4
    strobe_pos_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ctl_strobe |-> (slot_idx == PREV_IDX && bit_idx == '0));

    // R5
    window_pos_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        port_en |-> (slot_idx == SIG_IDX));

    // R6
    hiz_match_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        sw_hiz == port_en);

    // R8
    window_len_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        port_en |-> (run_q < BITS_PER_SLOT));

    generate
        if (SIG_SLOT != 0) begin : g_nonzero
            // R7
            open_after_strobe_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
                $rose(port_en) |-> ($past(ctl_strobe) && $past(frame_n)));

            // R9
            truncate_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
                (rst_n && !frame_n) |=> (!port_en && !sw_hiz));
        end
    endgenerate

endmodule

bind tdm_sig_gate tdm_sig_gate_chk #(
    .NUM_SLOTS    (NUM_SLOTS),
    .BITS_PER_SLOT(BITS_PER_SLOT),
    .SIG_SLOT     (SIG_SLOT)
) u_chk (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .ctl_strobe(ctl_strobe),
    .port_en   (port_en),
    .sw_hiz    (sw_hiz),
    .slot_idx  (slot_idx),
    .bit_idx   (bit_idx)
);

// File: tb/tdm_sig_gate_test.sv
// Bench: behavioural reference of slot/bit position, compared every clock.
module tdm_sig_gate_test;
    logic       clk_bit = 1'b0;
    logic       rst_n   = 1'b0;
    logic       frame_n = 1'b1;
    logic       ctl_strobe, port_en, sw_hiz;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference position, updated by the model at each rising edge.
    int m_slot = -1;
    int m_bit  = -1;
    int run_len = 0;

    tdm_sig_gate uut (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .ctl_strobe(ctl_strobe),
        .port_en   (port_en),
        .sw_hiz    (sw_hiz),
        .slot_idx  (slot_idx),
        .bit_idx   (bit_idx)
    );

    always #2.5 clk_bit = ~clk_bit;

    // Reference model: the frame position the requirements describe.
    always @(posedge clk_bit) begin
        if (!rst_n || !frame_n) begin
            m_slot = 0;
            m_bit  = 7;
        end else if (m_bit > 0) begin
            m_bit = m_bit - 1;
        end else begin
            m_bit  = 7;
            m_slot = (m_slot + 1) % 32;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (slot %0d bit %0d)",
                     req, act, exp, m_slot, m_bit);
        end
    endtask

    // Compare all outputs with the model at the current position.
    task automatic compare();
        int e_str;
        int e_win;
        e_str = (m_slot == 15 && m_bit == 0) ? 1 : 0;
        e_win = (m_slot == 16) ? 1 : 0;
        chk(int'(slot_idx) == m_slot, "R3 slot", int'(slot_idx), m_slot);
        chk(int'(bit_idx) == m_bit, "R3 bit", int'(bit_idx), m_bit);
        chk(int'(ctl_strobe) == e_str, "R4 strobe", int'(ctl_strobe), e_str);
        chk(int'(port_en) == e_win, "R5 port_en", int'(port_en), e_win);
        chk(sw_hiz == port_en, "R6 hiz", int'(sw_hiz), int'(port_en));
        if (port_en) run_len++;
        else         run_len = 0;
        if (port_en) chk(run_len <= 8, "R8 run", run_len, 8);
    endtask

    // One clock: drive frame_n, let the edge pass, check mid-cycle.
    task automatic tick(input bit fv);
        frame_n = fv;
        @(posedge clk_bit);
        @(negedge clk_bit);
        compare();
    endtask

    task automatic go_to(input int s, input int b);
        for (int i = 0; i < 600 && !(m_slot == s && m_bit == b); i++) tick(1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_str;
        int n_hiz;
        int gaps[6] = '{37, 100, 513, 3, 250, 129};
        @(negedge clk_bit);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b1);
        // R1: reset state
        chk(slot_idx == 5'd0 && bit_idx == 3'd7, "R1 counters",
            int'({slot_idx, bit_idx}), 7);
        chk(!ctl_strobe && !port_en && !sw_hiz, "R1 flags",
            int'({ctl_strobe, port_en, sw_hiz}), 0);
        rst_n = 1'b1;

        // R3: free run over more than a frame, no pulse, wrap 31 -> 0
        for (int i = 0; i < 300; i++) tick(1'b1);

        // R2: pulses at irregular gaps re-align from any count
        foreach (gaps[k]) begin
            for (int i = 0; i < gaps[k]; i++) tick(1'b1);
            tick(1'b0);
            chk(slot_idx == 5'd0 && bit_idx == 3'd7, "R2 realign",
                int'({slot_idx, bit_idx}), 7);
        end

        // R9: pulse inside the window truncates it
        go_to(16, 4);
        tick(1'b0);
        chk(!port_en && !sw_hiz, "R9 truncate", int'({port_en, sw_hiz}), 0);

        // R7: pulse on the strobe bit keeps the window shut
        go_to(15, 0);
        chk(ctl_strobe == 1'b1, "R4 strobe present", int'(ctl_strobe), 1);
        tick(1'b0);
        chk(!port_en, "R7 no open", int'(port_en), 0);
        for (int i = 0; i < 300; i++) begin
            tick(1'b1);
            if (m_slot == 16) chk(port_en, "R7 later open", int'(port_en), 1);
        end

        // R4 R5 R6: four aligned frames, pulse every 256 cycles
        go_to(31, 0);
        n_str = 0;
        n_hiz = 0;
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 256; i++) begin
                tick(i == 0 ? 1'b0 : 1'b1);
                n_str += int'(ctl_strobe);
                n_hiz += int'(sw_hiz);
            end
        end
        chk(n_str == 4, "R4 per-frame strobe", n_str, 4);
        chk(n_hiz == 32, "R6 per-frame hiz", n_hiz, 32);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule